// File: doc/BRIEF.md
# Flag-Generating Integer ALU with Condition-Code Register

This block is the execute-stage arithmetic and logic unit of a small CPU whose register file holds 8-bit, 16-bit and 32-bit views of the same registers. Each cycle it takes an operation code, an operand size and two operands. It returns a result masked to the selected size and a write-back enable. It also updates a packed eight-bit condition-code register that sits inside the block. The result path is purely combinational. The condition-code register updates on the rising clock edge that ends the cycle in which the operation is presented.

Operations fall into classes, and each class follows its own flag rule. Plain arithmetic rewrites N, Z, V and C. Carry-chained arithmetic can only keep Z or clear it, so a multi-word zero test works across a run of chained instructions. Increment and decrement leave C alone. Logical, move and extend operations clear V and keep C. Address adjustment never touches the flags. A separate group combines an immediate byte with the whole condition-code register, or loads it directly. The block does not include instruction decode, the register file or memory.

Top module: `flag_alu`

## Requirements
- R1: The condition-code register `ccr_o` holds, from bit 7 down: interrupt mask, user bit, half-carry, user bit, N (bit 3), Z (bit 2), V (bit 1), C (bit 0). While `rst` is high at a clock edge it becomes 8'h80, whatever operation is presented. Bits 7..4 change only through the condition-code operations of R11.
- R2: Operation codes on `op_i`: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-carry, 4 compare, 5 negate, 6 AND, 7 OR, 8 XOR, 9 NOT, 10 move, 11 increment, 12 decrement, 13 sign-extend, 14 zero-extend, 15 address add, 16 address subtract, 17 AND into CCR, 18 OR into CCR, 19 XOR into CCR, 20 load CCR. `size_i` 0 selects byte, 1 word, 2 or 3 long. Operand bits above the selected size are ignored and `res_o` bits above it read zero. `wr_en_o` is 1 for codes 0..3 and 5..16 and 0 otherwise.
- R3: Add and add-with-carry (`a_i + b_i`, plus C for code 1) set N from the result's top bit and C from the carry out of the top bit of the selected size. V is set when both operands share a sign and the result's sign differs. For plain add, Z is set exactly when the sized result is zero.
- R4: Subtract, subtract-with-carry (`a_i - b_i`, minus C for code 3) and compare set C on an unsigned borrow. V is set when the operand signs differ and the result's sign differs from `a_i`. Compare updates the flags like subtract but holds `wr_en_o` at 0.
- R5: Negate returns `0 - a_i`. It sets V only when `a_i` is the most negative value of its size, sets C whenever `a_i` is non-zero, and sets N and Z from the result.
- R6: Add-with-carry and subtract-with-carry clear Z when the result is non-zero and otherwise leave Z as it was; they never set it.
- R7: AND, OR, XOR, NOT (of `a_i`) and move (of `b_i`) set N from the result's top bit and Z on a zero result, clear V and leave C unchanged.
- R8: Increment and decrement step `a_i` by one. V is set only when increment goes from the largest positive value to the sign boundary, or when decrement goes the other way. C is left unchanged. N and Z follow the result.
- R9: Sign-extend copies bit 7 into bits 15..8 at word size, or bit 15 into bits 31..16 at long size. Zero-extend clears those bits. Flags follow R7.
- R10: Address add and address subtract compute the full 32-bit `a_i` plus or minus `lit_i`, whatever `size_i` is, and leave all eight condition-code bits unchanged.
- R11: Codes 17, 18 and 19 replace the condition-code register with its bitwise AND, OR or XOR with `lit_i`. Code 20 replaces it with `lit_i`. These codes drive `res_o` to zero.
- R12: Codes 21..31 leave the condition-code register unchanged and drive `res_o` and `wr_en_o` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the condition-code register updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code (R2) |
| size_i | input | 2 | Operand size: 0 byte, 1 word, 2 or 3 long |
| a_i | input | 32 | First (destination) operand |
| b_i | input | 32 | Second (source) operand |
| lit_i | input | 8 | Immediate for address adjustment and condition-code operations |
| res_o | output | 32 | Result, zero above the selected size |
| wr_en_o | output | 1 | Result should be written back to the register file |
| ccr_o | output | 8 | Packed condition-code register |

## Verification
Some rules can be checked on every cycle from the ports alone, and the bound checker covers these. Address operations and unassigned codes must freeze the whole register. Logical operations must clear V. Increment and decrement must keep C. A chained operation must never raise Z. Compare must never request write-back. A byte result must stay narrow. Plain arithmetic must set Z to match the result just produced. The exact V and C values at size boundaries, the sign and zero extension patterns, the immediate combinations into the register, and the behaviour of a two-instruction chained add can only be shown by the bench. It preloads the register, applies each operation, and compares the result and the updated flags against values worked out from the requirements.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    localparam int DATA_W = 32;
    localparam int CCR_W  = 8;

    // Condition-code bit positions (fixed: a neighbour decodes them)
    localparam int CCR_C = 0;
    localparam int CCR_V = 1;
    localparam int CCR_Z = 2;
    localparam int CCR_N = 3;

    typedef enum logic [4:0] {
        OP_ADD   = 5'd0,
        OP_ADDC  = 5'd1,
        OP_SUB   = 5'd2,
        OP_SUBC  = 5'd3,
        OP_CMP   = 5'd4,
        OP_NEG   = 5'd5,
        OP_AND   = 5'd6,
        OP_OR    = 5'd7,
        OP_XOR   = 5'd8,
        OP_NOT   = 5'd9,
        OP_MOV   = 5'd10,
        OP_INC   = 5'd11,
        OP_DEC   = 5'd12,
        OP_EXTS  = 5'd13,
        OP_EXTU  = 5'd14,
        OP_ADRA  = 5'd15,
        OP_ADRS  = 5'd16,
        OP_CCAND = 5'd17,
        OP_CCOR  = 5'd18,
        OP_CCXOR = 5'd19,
        OP_CCLD  = 5'd20
    } alu_op_e;

    typedef enum logic [2:0] {
        CL_ARITH,   // add, sub, cmp, neg: all four flags
        CL_CHAIN,   // carry-chained: Z may only stay or clear
        CL_STEP,    // inc/dec: C held
        CL_LOGIC,   // logical, move, extend: V cleared, C held
        CL_ADDR,    // address adjust: flags held
        CL_CCR,     // immediate ops on the condition-code byte
        CL_IDLE     // unassigned codes
    } op_class_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    function automatic op_class_e classify(input logic [4:0] op);
        case (op)
            OP_ADD, OP_SUB, OP_CMP, OP_NEG:                 return CL_ARITH;
            OP_ADDC, OP_SUBC:                               return CL_CHAIN;
            OP_INC, OP_DEC:                                 return CL_STEP;
            OP_AND, OP_OR, OP_XOR, OP_NOT, OP_MOV,
            OP_EXTS, OP_EXTU:                               return CL_LOGIC;
            OP_ADRA, OP_ADRS:                               return CL_ADDR;
            OP_CCAND, OP_CCOR, OP_CCXOR, OP_CCLD:           return CL_CCR;
            default:                                        return CL_IDLE;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic sign_of(input logic [DATA_W-1:0] v, input logic [1:0] sz);
        case (sz)
            2'd0:    return v[7];
            2'd1:    return v[15];
            default: return v[31];
        endcase
    endfunction

    function automatic logic carry_of(input logic [DATA_W:0] v, input logic [1:0] sz);
        case (sz)
            2'd0:    return v[8];
            2'd1:    return v[16];
            default: return v[32];
        endcase
    endfunction

endpackage

// File: rtl/flag_alu_arith.sv
module flag_alu_arith
    import flag_alu_pkg::*;
(
    input  logic [4:0]        op,
    input  logic [1:0]        sz,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    input  logic              zin,
    output logic [DATA_W-1:0] res,
    output flags_t            fl
);
    logic [DATA_W-1:0] mask;
    logic [DATA_W:0]   xm;
    logic [DATA_W:0]   ym;
    logic [DATA_W:0]   ci;
    logic [DATA_W:0]   wide;
    logic              sub;
    logic              chain;
    logic              sx;
    logic              sy;
    logic              sr;

    always_comb begin
        mask  = size_mask(sz);
        sub   = 1'b0;
        chain = 1'b0;
        xm    = {1'b0, a & mask};
        ym    = {1'b0, b & mask};
        ci    = '0;
        case (op)
            OP_ADDC: begin
                chain = 1'b1;
                ci    = {{DATA_W{1'b0}}, cin};
            end
            OP_SUB, OP_CMP: sub = 1'b1;
            OP_SUBC: begin
                sub   = 1'b1;
                chain = 1'b1;
                ci    = {{DATA_W{1'b0}}, cin};
            end
            OP_NEG: begin
                sub = 1'b1;
                xm  = '0;
                ym  = {1'b0, a & mask};
            end
            OP_INC: ym = {{DATA_W{1'b0}}, 1'b1};
            OP_DEC: begin
                sub = 1'b1;
                ym  = {{DATA_W{1'b0}}, 1'b1};
            end
            default: ;
        endcase

        wide = sub ? (xm - ym - ci) : (xm + ym + ci);
        res  = wide[DATA_W-1:0] & mask;

        sx = sign_of(xm[DATA_W-1:0], sz);
        sy = sign_of(ym[DATA_W-1:0], sz);
        sr = sign_of(res, sz);

        fl.n = sr;
        fl.z = (res == '0) && (!chain || zin);
        fl.v = sub ? ((sx != sy) && (sr != sx)) : ((sx == sy) && (sr != sx));
        fl.c = carry_of(wide, sz);
    end

endmodule

// File: rtl/flag_alu_logic.sv
module flag_alu_logic
    import flag_alu_pkg::*;
(
    input  logic [4:0]        op,
    input  logic [1:0]        sz,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res,
    output logic              n,
    output logic              z
);
    logic [DATA_W-1:0] raw;
    logic [DATA_W-1:0] sext;
    logic [DATA_W-1:0] zext;

    always_comb begin
        case (sz)
            2'd0: begin
                sext = a;
                zext = a;
            end
            2'd1: begin
                sext = {{(DATA_W-16){1'b0}}, {8{a[7]}}, a[7:0]};
                zext = {{(DATA_W-8){1'b0}}, a[7:0]};
            end
            default: begin
                sext = {{(DATA_W-16){a[15]}}, a[15:0]};
                zext = {{(DATA_W-16){1'b0}}, a[15:0]};
            end
        endcase

        case (op)
            OP_AND:  raw = a & b;
            OP_OR:   raw = a | b;
            OP_XOR:  raw = a ^ b;
            OP_NOT:  raw = ~a;
            OP_MOV:  raw = b;
            OP_EXTS: raw = sext;
            OP_EXTU: raw = zext;
            default: raw = '0;
        endcase

        res = raw & size_mask(sz);
        n   = sign_of(res, sz);
        z   = (res == '0);
    end

endmodule

// File: rtl/flag_alu_ccr.sv
module flag_alu_ccr
    import flag_alu_pkg::*;
#(
    parameter logic [CCR_W-1:0] CCR_INIT = 8'h80
)(
    input  logic             clk,
    input  logic             rst,
    input  op_class_e        cls,
    input  logic [4:0]       op,
    input  logic [CCR_W-1:0] lit,
    input  flags_t           afl,
    input  logic             ln,
    input  logic             lz,
    output logic [CCR_W-1:0] ccr_q
);
    logic [CCR_W-1:0] nxt;

    always_comb begin
        nxt = ccr_q;
        case (cls)
            CL_ARITH, CL_CHAIN: begin
                nxt[CCR_N] = afl.n;
                nxt[CCR_Z] = afl.z;
                nxt[CCR_V] = afl.v;
                nxt[CCR_C] = afl.c;
            end
            CL_STEP: begin
                nxt[CCR_N] = afl.n;
                nxt[CCR_Z] = afl.z;
                nxt[CCR_V] = afl.v;
            end
            CL_LOGIC: begin
                nxt[CCR_N] = ln;
                nxt[CCR_Z] = lz;
                nxt[CCR_V] = 1'b0;
            end
            CL_CCR: begin
                case (op)
                    OP_CCAND: nxt = ccr_q & lit;
                    OP_CCOR:  nxt = ccr_q | lit;
                    OP_CCXOR: nxt = ccr_q ^ lit;
                    default:  nxt = lit;
                endcase
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ccr_q <= CCR_INIT;
        else     ccr_q <= nxt;
    end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter logic [7:0] CCR_INIT = 8'h80
)(
    input  logic        clk,
    input  logic        rst,
    input  logic [4:0]  op_i,
    input  logic [1:0]  size_i,
    input  logic [31:0] a_i,
    input  logic [31:0] b_i,
    input  logic [7:0]  lit_i,
    output logic [31:0] res_o,
    output logic        wr_en_o,
    output logic [7:0]  ccr_o
);
    op_class_e         cls;
    logic [DATA_W-1:0] arith_res;
    flags_t            arith_fl;
    logic [DATA_W-1:0] logic_res;
    logic              logic_n;
    logic              logic_z;
    logic [DATA_W-1:0] lit_ext;
    logic [DATA_W-1:0] addr_res;

    assign cls     = classify(op_i);
    assign lit_ext = {{(DATA_W-CCR_W){1'b0}}, lit_i};
    assign addr_res = (op_i == OP_ADRS) ? (a_i - lit_ext) : (a_i + lit_ext);

    flag_alu_arith u_arith (
        .op  (op_i),
        .sz  (size_i),
        .a   (a_i),
        .b   (b_i),
        .cin (ccr_o[CCR_C]),
        .zin (ccr_o[CCR_Z]),
        .res (arith_res),
        .fl  (arith_fl)
    );

    flag_alu_logic u_logic (
        .op  (op_i),
        .sz  (size_i),
        .a   (a_i),
        .b   (b_i),
        .res (logic_res),
        .n   (logic_n),
        .z   (logic_z)
    );

    flag_alu_ccr #(.CCR_INIT(CCR_INIT)) u_ccr (
        .clk   (clk),
        .rst   (rst),
        .cls   (cls),
        .op    (op_i),
        .lit   (lit_i),
        .afl   (arith_fl),
        .ln    (logic_n),
        .lz    (logic_z),
        .ccr_q (ccr_o)
    );

    always_comb begin
        case (cls)
            CL_ARITH: begin
                res_o   = arith_res;
                wr_en_o = (op_i != OP_CMP);
            end
            CL_CHAIN, CL_STEP: begin
                res_o   = arith_res;
                wr_en_o = 1'b1;
            end
            CL_LOGIC: begin
                res_o   = logic_res;
                wr_en_o = 1'b1;
            end
            CL_ADDR: begin
                res_o   = addr_res;
                wr_en_o = 1'b1;
            end
            default: begin
                res_o   = '0;
                wr_en_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk
    import flag_alu_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [4:0]  op_i,
    input logic [1:0]  size_i,
    input logic [31:0] a_i,
    input logic [31:0] res_o,
    input logic        wr_en_o,
    input logic [7:0]  ccr_o
);
    op_class_e   k;
    logic [31:0] smask;
    logic [31:0] min_neg;

    assign k       = classify(op_i);
    assign smask   = size_mask(size_i);
    assign min_neg = smask ^ (smask >> 1);

    AST_CCR_UPPER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (k != CL_CCR) |=> (ccr_o[7:4] == $past(ccr_o[7:4])));                 // R1

    AST_BYTE_RESULT_NARROW: assert property (@(posedge clk) disable iff (rst)
        (size_i == 2'd0 && k != CL_ADDR) |-> (res_o[31:8] == 24'd0));          // R2

    AST_ARITH_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
        (k == CL_ARITH) |=> (ccr_o[CCR_Z] == ($past(res_o) == 32'd0)));        // R3

    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_CMP) |-> !wr_en_o);                                        // R4

    AST_NEG_MIN_V: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_NEG && (a_i & smask) == min_neg) |=> ccr_o[CCR_V]);        // R5

    AST_CHAIN_Z_STICKY: assert property (@(posedge clk) disable iff (rst)
        (k == CL_CHAIN && !ccr_o[CCR_Z]) |=> !ccr_o[CCR_Z]);                   // R6

    AST_LOGIC_V_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (k == CL_LOGIC) |=> !ccr_o[CCR_V]);                                    // R7

    AST_STEP_C_HOLD: assert property (@(posedge clk) disable iff (rst)
        (k == CL_STEP) |=> (ccr_o[CCR_C] == $past(ccr_o[CCR_C])));             // R8

    AST_ADDR_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (k == CL_ADDR) |=> $stable(ccr_o));                                    // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (k == CL_IDLE) |-> (!wr_en_o && res_o == 32'd0) ##1 $stable(ccr_o));   // R12

endmodule

bind flag_alu flag_alu_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .op_i    (op_i),
    .size_i  (size_i),
    .a_i     (a_i),
    .res_o   (res_o),
    .wr_en_o (wr_en_o),
    .ccr_o   (ccr_o)
);

// File: tb/flag_alu_tb.sv
module flag_alu_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 43;

    typedef struct packed {
        logic [4:0]  op;
        logic [1:0]  sz;
        logic [31:0] a;
        logic [31:0] b;
        logic [7:0]  lit;
        logic [7:0]  cin;
        logic [31:0] res;
        logic        wr;
        logic [7:0]  cout;
        int          req;
    } vec_t;

    // op, size, a, b, lit, ccr before, result, write, ccr after, requirement
    localparam vec_t VEC [NV] = '{
        '{5'd0,  2'd0, 32'h1234567F, 32'h00000001, 8'h00, 8'h00, 32'h00000080, 1'b1, 8'h0A, 3},  // R3 byte V, upper ignored
        '{5'd0,  2'd0, 32'h000000FF, 32'h00000001, 8'h00, 8'h00, 32'h00000000, 1'b1, 8'h05, 3},  // R3 byte carry
        '{5'd0,  2'd1, 32'h00008000, 32'h00008000, 8'h00, 8'h00, 32'h00000000, 1'b1, 8'h07, 3},  // R3 word
        '{5'd0,  2'd2, 32'hFFFFFFFF, 32'h00000002, 8'h00, 8'h00, 32'h00000001, 1'b1, 8'h01, 3},  // R3 long carry
        '{5'd0,  2'd2, 32'h7FFFFFFF, 32'h00000001, 8'h00, 8'h00, 32'h80000000, 1'b1, 8'h0A, 3},  // R3 long V
        '{5'd1,  2'd0, 32'h00000010, 32'h00000020, 8'h00, 8'h81, 32'h00000031, 1'b1, 8'h80, 3},  // R3 carry in
        '{5'd1,  2'd0, 32'h000000FF, 32'h00000000, 8'h00, 8'h05, 32'h00000000, 1'b1, 8'h05, 6},  // R6 Z kept
        '{5'd1,  2'd1, 32'h00000000, 32'h00000000, 8'h00, 8'h00, 32'h00000000, 1'b1, 8'h00, 6},  // R6 Z never set
        '{5'd2,  2'd0, 32'h00000000, 32'h00000001, 8'h00, 8'h00, 32'h000000FF, 1'b1, 8'h09, 4},  // R4 borrow
        '{5'd2,  2'd0, 32'h00000080, 32'h00000001, 8'h00, 8'h00, 32'h0000007F, 1'b1, 8'h02, 4},  // R4 V
        '{5'd2,  2'd2, 32'h00000005, 32'h00000005, 8'h00, 8'h0B, 32'h00000000, 1'b1, 8'h04, 4},  // R4 zero
        '{5'd3,  2'd1, 32'h00000000, 32'h00000000, 8'h00, 8'h05, 32'h0000FFFF, 1'b1, 8'h09, 6},  // R6 Z cleared
        '{5'd3,  2'd0, 32'h00000005, 32'h00000004, 8'h00, 8'h05, 32'h00000000, 1'b1, 8'h04, 4},  // R4 borrow in
        '{5'd4,  2'd0, 32'h00000003, 32'h00000005, 8'h00, 8'h00, 32'h000000FE, 1'b0, 8'h09, 4},  // R4 compare
        '{5'd4,  2'd1, 32'h00001234, 32'h00001234, 8'h00, 8'h00, 32'h00000000, 1'b0, 8'h04, 4},  // R4 compare equal
        '{5'd5,  2'd0, 32'h00000080, 32'h00000000, 8'h00, 8'h00, 32'h00000080, 1'b1, 8'h0B, 5},  // R5 most negative
        '{5'd5,  2'd1, 32'h00000000, 32'h00000000, 8'h00, 8'h00, 32'h00000000, 1'b1, 8'h04, 5},  // R5 zero
        '{5'd5,  2'd2, 32'h00000001, 32'h00000000, 8'h00, 8'h00, 32'hFFFFFFFF, 1'b1, 8'h09, 5},  // R5 long
        '{5'd6,  2'd0, 32'h000000F0, 32'h0000000F, 8'h00, 8'h03, 32'h00000000, 1'b1, 8'h05, 7},  // R7 and
        '{5'd7,  2'd1, 32'h00008000, 32'h00000001, 8'h00, 8'h02, 32'h00008001, 1'b1, 8'h08, 7},  // R7 or
        '{5'd8,  2'd2, 32'hFFFF0000, 32'hFFFFFFFF, 8'h00, 8'h01, 32'h0000FFFF, 1'b1, 8'h01, 7},  // R7 xor
        '{5'd9,  2'd0, 32'h000000AA, 32'h00000000, 8'h00, 8'h00, 32'h00000055, 1'b1, 8'h00, 7},  // R7 not
        '{5'd10, 2'd1, 32'h00001234, 32'h00008000, 8'h00, 8'h04, 32'h00008000, 1'b1, 8'h08, 7},  // R7 move
        '{5'd10, 2'd2, 32'h00001234, 32'h00000000, 8'h00, 8'h09, 32'h00000000, 1'b1, 8'h05, 7},  // R7 move zero
        '{5'd11, 2'd0, 32'h0000007F, 32'h00000000, 8'h00, 8'h01, 32'h00000080, 1'b1, 8'h0B, 8},  // R8 inc V
        '{5'd11, 2'd1, 32'h0000FFFF, 32'h00000000, 8'h00, 8'h00, 32'h00000000, 1'b1, 8'h04, 8},  // R8 inc wrap
        '{5'd12, 2'd0, 32'h00000080, 32'h00000000, 8'h00, 8'h00, 32'h0000007F, 1'b1, 8'h02, 8},  // R8 dec V
        '{5'd12, 2'd2, 32'h00000000, 32'h00000000, 8'h00, 8'h01, 32'hFFFFFFFF, 1'b1, 8'h09, 8},  // R8 dec wrap
        '{5'd13, 2'd1, 32'h12345680, 32'h00000000, 8'h00, 8'h00, 32'h0000FF80, 1'b1, 8'h08, 9},  // R9 sext word
        '{5'd13, 2'd2, 32'h00007FFF, 32'h00000000, 8'h00, 8'h00, 32'h00007FFF, 1'b1, 8'h00, 9},  // R9 sext positive
        '{5'd13, 2'd2, 32'hAAAA8001, 32'h00000000, 8'h00, 8'h00, 32'hFFFF8001, 1'b1, 8'h08, 9},  // R9 sext long
        '{5'd14, 2'd1, 32'h12345680, 32'h00000000, 8'h00, 8'h08, 32'h00000080, 1'b1, 8'h00, 9},  // R9 zext word
        '{5'd14, 2'd2, 32'hFFFF0000, 32'h00000000, 8'h00, 8'h01, 32'h00000000, 1'b1, 8'h05, 9},  // R9 zext long
        '{5'd15, 2'd0, 32'hFFFFFFFF, 32'h00000000, 8'h04, 8'h0F, 32'h00000003, 1'b1, 8'h0F, 10}, // R10 add
        '{5'd16, 2'd1, 32'h00000001, 32'h00000000, 8'h02, 8'h00, 32'hFFFFFFFF, 1'b1, 8'h00, 10}, // R10 sub
        '{5'd17, 2'd0, 32'h00000000, 32'h00000000, 8'h7E, 8'hFF, 32'h00000000, 1'b0, 8'h7E, 11}, // R11 and
        '{5'd18, 2'd0, 32'h00000000, 32'h00000000, 8'h30, 8'h81, 32'h00000000, 1'b0, 8'hB1, 11}, // R11 or
        '{5'd19, 2'd0, 32'h00000000, 32'h00000000, 8'hFF, 8'h5A, 32'h00000000, 1'b0, 8'hA5, 11}, // R11 xor
        '{5'd20, 2'd0, 32'h00000000, 32'h00000000, 8'h3C, 8'hC3, 32'h00000000, 1'b0, 8'h3C, 11}, // R11 load
        '{5'd21, 2'd2, 32'h00000001, 32'h00000001, 8'h11, 8'h6B, 32'h00000000, 1'b0, 8'h6B, 12}, // R12
        '{5'd31, 2'd0, 32'h00000001, 32'h00000001, 8'hFF, 8'h94, 32'h00000000, 1'b0, 8'h94, 12}, // R12
        '{5'd0,  2'd3, 32'hFFFFFFFF, 32'h00000001, 8'h00, 8'h00, 32'h00000000, 1'b1, 8'h05, 2},  // R2 size 3 long
        '{5'd6,  2'd0, 32'hABCDEF12, 32'hFFFFFF1F, 8'h00, 8'h00, 32'h00000012, 1'b1, 8'h00, 2}   // R2 masking
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  op = 5'd21;
    logic [1:0]  sz = 2'd0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [7:0]  lit = '0;
    logic [31:0] res_o;
    logic        wr_en_o;
    logic [7:0]  ccr_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flag_alu u_dut (
        .clk     (clk),
        .rst     (rst),
        .op_i    (op),
        .size_i  (sz),
        .a_i     (a),
        .b_i     (b),
        .lit_i   (lit),
        .res_o   (res_o),
        .wr_en_o (wr_en_o),
        .ccr_o   (ccr_o)
    );

    task automatic check(input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [4:0] o, input logic [1:0] s,
                         input logic [31:0] x, input logic [31:0] y,
                         input logic [7:0] l);
        op = o; sz = s; a = x; b = y; lit = l;
    endtask

    initial begin
        // R1: reset value, held even while a load is presented
        drive(5'd20, 2'd0, '0, '0, 8'h00);
        repeat (3) @(negedge clk);
        check(1, "reset ccr", {24'd0, ccr_o}, 32'h80);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(5'd20, 2'd0, '0, '0, VEC[i].cin);
            @(negedge clk);
            drive(VEC[i].op, VEC[i].sz, VEC[i].a, VEC[i].b, VEC[i].lit);
            #1;
            check(VEC[i].req, $sformatf("vec %0d result", i), res_o, VEC[i].res);
            check(VEC[i].req, $sformatf("vec %0d write", i), {31'd0, wr_en_o}, {31'd0, VEC[i].wr});
            @(negedge clk);
            check(VEC[i].req, $sformatf("vec %0d ccr", i), {24'd0, ccr_o}, {24'd0, VEC[i].cout});
            drive(5'd21, 2'd0, '0, '0, 8'h00);
        end

        // R6: two-word chained add whose total is zero keeps Z set
        @(negedge clk);
        drive(5'd20, 2'd0, '0, '0, 8'h00);
        @(negedge clk);
        drive(5'd0, 2'd2, 32'h00000001, 32'hFFFFFFFF, 8'h00);
        @(negedge clk);
        check(6, "chain low ccr", {24'd0, ccr_o}, 32'h05);
        drive(5'd1, 2'd2, 32'hFFFFFFFF, 32'h00000000, 8'h00);
        #1;
        check(6, "chain high result", res_o, 32'h0);
        @(negedge clk);
        check(6, "chain high ccr", {24'd0, ccr_o}, 32'h05);

        // R6: chained subtract with non-zero high word clears Z
        drive(5'd3, 2'd2, 32'h00000002, 32'h00000000, 8'h00);
        #1;
        check(6, "chain sub result", res_o, 32'h1);
        @(negedge clk);
        check(6, "chain sub ccr", {24'd0, ccr_o}, 32'h00);

        // R1: reset reasserted mid-run restores the initial value
        drive(5'd20, 2'd0, '0, '0, 8'h3C);
        @(negedge clk);
        check(11, "load before reset", {24'd0, ccr_o}, 32'h3C);
        rst = 1'b1;
        @(negedge clk);
        check(1, "reset again", {24'd0, ccr_o}, 32'h80);
        rst = 1'b0;
        drive(5'd21, 2'd0, '0, '0, 8'h00);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule